// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block sits on a two-wire I2C bus as a slave and lets an external master read and write a small bank of byte registers that lives outside the block. The block watches the clock and data lines, recognises START, repeated START and STOP, and compares the 7-bit device address against its own. Only a match with the write direction is followed by a sub-address byte and data bytes. A read is made with a write phase that sets the sub-address, then a repeated START and the address with the read direction. Outputs to the bus are open-drain requests: `sda_oe` pulls data low and `scl_hold` pulls clock low.

The sub-address byte does two jobs. Its low seven bits give the first register. Its top bit selects whether the register pointer advances by one after each byte of the burst, wrapping within seven bits, or stays on one register for the whole burst. Before each byte it sends, the slave stretches the clock for `STRETCH` system cycles while it fetches the byte from the bank.

The controller has eleven states. IDLE leaves on START to DEV_ADDR. DEV_ADDR collects eight bits and goes to DEV_ACK on a match or to SKIP otherwise. DEV_ACK goes to SUB_ADDR for a write or RD_LOAD for a read. SUB_ADDR leads to SUB_ACK. SUB_ACK leads to WR_DATA. WR_DATA and WR_ACK alternate, one write strobe per byte. RD_LOAD leads to RD_DATA, which leads to RD_ACK. RD_ACK returns to RD_LOAD on a master acknowledge and goes to SKIP on a not-acknowledge. START from any state goes to DEV_ADDR, and STOP from any state goes to IDLE.

Top module: `i2c_regfile_slave`

## Requirements
- R1: While reset is asserted, `sda_oe`, `scl_hold` and `reg_we` are all 0.
- R2: When the address byte (bits 7..1 equal to `DEV_ADDR`, bit 0 the direction, sent MSB first) matches, the slave pulls SDA low during the ninth clock.
- R3: When the address does not match, the slave leaves SDA released during the ninth clock and for the rest of the transfer, and it issues no register writes until the next START.
- R4: In a write, each data byte after the sub-address is written to the bank MSB first, with exactly one single-cycle `reg_we` pulse per byte, and the slave acknowledges each byte.
- R5: When sub-address bit 7 is 1, the register pointer starts at bits 6..0 and advances by one after every byte written or read, wrapping from 0x7F to 0x00.
- R6: When sub-address bit 7 is 0, every byte of the burst goes to the register given by bits 6..0.
- R7: After a repeated START and the address with the read bit (bit 0 = 1), the slave sends bytes MSB first from the current register pointer, and SDA changes only while SCL is low.
- R8: A master acknowledge (SDA low in the ninth clock) makes the slave send another byte. A not-acknowledge (SDA high) makes the slave release SDA until STOP or START.
- R9: Before each byte it sends, the slave holds SCL low for `STRETCH` system cycles and then releases it.
- R10: A START at any point, including in the middle of a write burst, restarts reception of the device address and keeps the register pointer.
- R11: A STOP (SDA rising while SCL is high) returns the slave to IDLE with SDA and SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_hold | output | 1 | 1 pulls the clock line low (clock stretch) |
| reg_addr | output | 7 | Register bank address (current pointer) |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Register bank write strobe, one cycle per byte |
| reg_rdata | input | 8 | Register bank read data for `reg_addr` |

## Verification
The bench aims at pointer wrap from 0x7F to 0x00. A design that carried into bit 7 or stopped at the top would write or read the wrong neighbour. It sends fixed-address bursts, where an off-by-one pointer step would scatter bytes across several registers. It also sends a repeated START in the middle of a write: a design that did not restart address reception, or that reset the pointer, would return the wrong byte on the following read. It addresses a foreign device, where any stray acknowledge or write strobe would show up on SDA or in the bank. It also ends reads with a not-acknowledge, where a slave that kept driving would corrupt the STOP.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } rf_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe[0] <= scl_in;
                    sda_pipe[0] <= sda_in;
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sub_ptr.sv
module i2c_sub_ptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_inc,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          auto_inc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            auto_inc <= 1'b0;
        end else if (load) begin
            addr     <= load_addr;
            auto_inc <= load_inc;
        end else if (step && auto_inc) begin
            addr     <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5C,
    parameter int         STRETCH     = 24,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       scl_hold,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam int BYTE_W = 8;
    localparam int RA_W   = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int HOLD_W = $clog2(STRETCH + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(STRETCH - 1);

    rf_state_e          state, nstate;
    logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  rx_sh, tx_sh;
    logic [HOLD_W-1:0]  hold_cnt;
    logic               rw_q, mack_q;
    logic               byte_in_done;
    logic               ptr_load, ptr_step, auto_inc;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_in_done = scl_fall && (bit_cnt == CNT_FULL);
    assign ptr_load     = (state == ST_SUB) && byte_in_done;
    assign ptr_step     = ((state == ST_WR) && byte_in_done) ||
                          ((state == ST_RD_LOAD) && (nstate == ST_RD));

    i2c_sub_ptr #(.AW(RA_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_addr (rx_sh[RA_W-1:0]),
        .load_inc  (rx_sh[BYTE_W-1]),
        .step      (ptr_step),
        .addr      (reg_addr),
        .auto_inc  (auto_inc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        if (start_det) begin
            nstate = ST_DEV;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nstate = ST_IDLE;
                ST_DEV:     if (byte_in_done)
                                nstate = (rx_sh[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK: if (scl_fall) nstate = rw_q ? ST_RD_LOAD : ST_SUB;
                ST_SUB:     if (byte_in_done) nstate = ST_SUB_ACK;
                ST_SUB_ACK: if (scl_fall) nstate = ST_WR;
                ST_WR:      if (byte_in_done) nstate = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) nstate = ST_WR;
                ST_RD_LOAD: if (hold_cnt == HOLD_END) nstate = ST_RD;
                ST_RD:      if (scl_fall && bit_cnt == CNT_LAST) nstate = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall) nstate = mack_q ? ST_RD_LOAD : ST_SKIP;
                ST_SKIP:    nstate = ST_SKIP;
                default:    nstate = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            hold_cnt <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            if (start_det || nstate != state) begin
                bit_cnt <= '0;
            end else if (scl_rise && (state == ST_DEV || state == ST_SUB || state == ST_WR)) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (scl_fall && state == ST_RD) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end

            if (scl_rise && (state == ST_DEV || state == ST_SUB || state == ST_WR))
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};

            if (state == ST_DEV && byte_in_done)
                rw_q <= rx_sh[0];

            if (state == ST_RD_LOAD) begin
                hold_cnt <= hold_cnt + HOLD_W'(1);
                if (nstate == ST_RD) tx_sh <= reg_rdata;
            end else begin
                hold_cnt <= '0;
                if (state == ST_RD && scl_fall)
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            end

            if (state == ST_RD_ACK && scl_rise)
                mack_q <= ~sda_s;
        end
    end

    // Outputs
    always_comb begin
        sda_oe    = 1'b0;
        scl_hold  = 1'b0;
        reg_we    = 1'b0;
        reg_wdata = rx_sh;
        unique case (state)
            ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:      sda_oe   = ~tx_sh[BYTE_W-1];
            ST_RD_LOAD: scl_hold = 1'b1;
            ST_WR:      reg_we   = byte_in_done && !start_det && !stop_det;
            default:    ;
        endcase
    end
endmodule

// File: rtl/i2c_regfile_sva.sv
module i2c_regfile_sva
    import i2c_rf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input rf_state_e  state,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       scl_hold,
    input logic       reg_we,
    input logic [6:0] reg_addr,
    input logic       auto_inc
);
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!sda_oe && !scl_hold && !reg_we);
        end
    end

    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe && !reg_we));

    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_autoinc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && auto_inc) |=> (reg_addr == 7'($past(reg_addr) + 7'd1)));

    p_fixed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !auto_inc) |=> $stable(reg_addr));

    p_sda_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    p_hold_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hold) |-> (state == ST_RD || state == ST_DEV || state == ST_IDLE));

    p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe && !scl_hold));
endmodule

bind i2c_regfile_slave i2c_regfile_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .scl_hold  (scl_hold),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .auto_inc  (auto_inc)
);

// File: tb/tb_i2c_regfile_slave.sv
`timescale 1ns/1ps
module tb_i2c_regfile_slave;
    localparam logic [6:0] DEV = 7'h5C;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, scl_hold, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic scl, sda;
    logic [7:0] bank [128];
    logic [7:0] ref_mem [128];
    int n_chk = 0, n_fail = 0, we_cnt = 0, stretch_cnt = 0;

    always #5 clk = ~clk;
    assign scl = scl_m & ~scl_hold;
    assign sda = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_regfile_slave #(.DEV_ADDR(DEV), .STRETCH(24), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_oe(sda_oe), .scl_hold(scl_hold), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'h00;
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    always @(negedge clk) if (scl_m && !scl) stretch_cnt <= stretch_cnt + 1;

    function automatic logic [6:0] next_addr(logic [6:0] a, logic inc);
        return inc ? 7'(a + 7'd1) : a;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl();
        while (!scl) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wait_scl(); wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wait_scl(); wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic bus_bit(input logic d, output logic s);
        sda_m = d; wq(Q);
        scl_m = 1'b1; wait_scl(); wq(Q);
        s = sda;
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic get_byte(input logic last, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            b = {b[6:0], s};
        end
        bus_bit(last, s);
    endtask

    task automatic cmp_bank(input string tag);
        int mism = 0;
        for (int i = 0; i < 128; i++) if (bank[i] !== ref_mem[i]) mism++;
        check(mism == 0, tag, mism, 0);
    endtask

    task automatic do_write(input logic [6:0] a0, input logic inc, input int n);
        logic ack;
        logic [6:0] a = a0;
        logic [7:0] d;
        int we0 = we_cnt;
        bus_start();
        put_byte({DEV, 1'b0}, ack); check(ack, "R2 dev ack", ack, 1);
        put_byte({inc, a0}, ack);   check(ack, "R4 sub ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            put_byte(d, ack);
            ref_mem[a] = d;
            a = next_addr(a, inc);
        end
        bus_stop();
        wq(4);
        check(we_cnt - we0 == n, "R4 strobes", we_cnt - we0, n);
        cmp_bank(inc ? "R5 bank" : "R6 bank");
    endtask

    task automatic do_read(input logic [6:0] a0, input logic inc, input int n);
        logic ack;
        logic [6:0] a = a0;
        logic [7:0] d;
        int st0;
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte({inc, a0}, ack);
        bus_start();
        put_byte({DEV, 1'b1}, ack); check(ack, "R2 read ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            st0 = stretch_cnt;
            get_byte(k == n - 1, d);
            check(stretch_cnt > st0, "R9 stretch", stretch_cnt - st0, 1);
            check(d == ref_mem[a], inc ? "R7/R5 read" : "R7/R6 read", d, ref_mem[a]);
            a = next_addr(a, inc);
        end
        wq(6);
        check(!sda_oe && !scl_hold, "R8 release after nack", sda_oe, 0);
        bus_stop();
        wq(4);
        check(!sda_oe && !scl_hold, "R11 idle after stop", {scl_hold, sda_oe}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int we0;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        wq(3);
        check(!sda_oe && !scl_hold && !reg_we, "R1 reset", {reg_we, scl_hold, sda_oe}, 0);
        rst_n = 1'b1;
        wq(5);

        do_write(7'h10, 1'b1, 3);
        do_read(7'h10, 1'b1, 3);

        do_write(7'h7E, 1'b1, 4);   // R5 wrap 7F -> 00
        do_read(7'h7E, 1'b1, 4);

        do_write(7'h20, 1'b0, 3);   // R6 same register
        check(ref_mem[8'h21] == 8'h00 && bank[8'h21] == 8'h00, "R6 neighbour", bank[8'h21], 0);
        do_read(7'h20, 1'b0, 2);

        // R3 foreign address
        we0 = we_cnt;
        bus_start();
        put_byte({DEV ^ 7'h01, 1'b0}, ack);
        check(!ack, "R3 nack", ack, 0);
        put_byte(8'h85, ack); check(!ack, "R3 no ack sub", ack, 0);
        put_byte(8'hA5, ack); check(!ack, "R3 no ack data", ack, 0);
        bus_stop(); wq(4);
        check(we_cnt == we0, "R3 no writes", we_cnt - we0, 0);
        cmp_bank("R3 bank");

        // R10 repeated START in the middle of a write burst
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte({1'b1, 7'h30}, ack);
        d = 8'h3C; put_byte(d, ack); ref_mem[7'h30] = d;
        ref_mem[7'h31] = 8'h00;
        bus_start();
        put_byte({DEV, 1'b1}, ack); check(ack, "R10 restart ack", ack, 1);
        get_byte(1'b1, d);
        check(d == ref_mem[7'h31], "R10 pointer kept", d, ref_mem[7'h31]);
        bus_stop(); wq(4);
        cmp_bank("R10 bank");

        for (int t = 0; t < 12; t++) begin
            logic [6:0] a = 7'($urandom);
            logic inc = 1'($urandom);
            int n = 1 + int'($urandom % 4);
            if ($urandom % 2) do_write(a, inc, n);
            else              do_read(a, inc, n);
        end

        finish_run();
    end
endmodule